// File: doc/BRIEF.md
# Burst address sequencer

This block generates the low-order address bits that step a synchronous burst memory through the beats of one burst. When a new burst begins, the block captures the start bits supplied by the bus side, and the next clock presents them unchanged as the first beat. While the active-low advance input is asserted, every clock moves the output to the next address of the burst. While advance is deasserted, the output holds its value and the burst is suspended. After the last beat, a further advance returns the output to the first beat of the same sequence.

A static ordering input chooses how the sequence is formed. With it high, the order is interleaved: each beat is the start value XOR the beat index. With it low, the order is linear: each beat is the start value plus the beat index, taken modulo the burst length. Both the address and a last-beat flag come straight from flip-flops. The default two-bit width gives four-beat bursts, and the width is a parameter.

Top module: `burst_seq`

## Requirements
- R1: A clock with `rst` high clears the output so that, after that edge, `addr` is 0 and `last_beat` is 0.
- R2: A clock with `load` high (and `rst` low) makes `addr` equal the `start_bits` sampled at that edge and restarts at beat index 0. `load` has priority over `adv_n`.
- R3: With `intlv` = 1, each advance clock (`adv_n` = 0, `load` = 0) makes `addr` equal start XOR beat index. For start 01 this gives 01,00,11,10.
- R4: With `intlv` = 0, each advance clock makes `addr` equal (start + beat index) modulo 4. For start 01 this gives 01,10,11,00.
- R5: A clock with `load` = 0 and `adv_n` = 1 leaves `addr` and `last_beat` unchanged (suspend).
- R6: An advance from beat index 3 wraps to beat index 0, so `addr` returns to the start value.
- R7: `last_beat` is 1 exactly while the beat index is 3, which is the fourth beat.
- R8: A `load` in the middle of a burst abandons that burst and begins a new one at beat index 0 with the new start bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Begin a new burst from `start_bits` |
| start_bits | input | AW (2) | Start value of the new burst |
| adv_n | input | 1 | Advance request, active low |
| intlv | input | 1 | Ordering: 1 selects interleaved, 0 selects linear |
| addr | output | AW (2) | Current low-order burst address, registered |
| last_beat | output | 1 | High while the current beat is the final one, registered |

## Verification
On every clock, the assertions check the load capture, the hold during a suspend, and the match between `addr` and a reference beat count under the ordering selected at that edge. They also check that `last_beat` rises only on the final beat and falls on the advance that wraps. Some behaviour appears only in the bench's directed scenarios: every start value walked through a full burst in both orderings, wrap-around over more than one lap, a reload partway through a burst, and a load that arrives in the same clock as an advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_INTLV  = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
// Holds the start value and beat index of the current burst.
module burst_beat_ctr #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_bits,
  input  logic          adv_n,
  output logic [AW-1:0] nxt_start,
  output logic [AW-1:0] nxt_idx,
  output logic          update
);
  logic [AW-1:0] start_q;
  logic [AW-1:0] idx_q;

  always_comb begin
    nxt_start = start_q;
    nxt_idx   = idx_q;
    update    = 1'b0;
    if (rst) begin
      nxt_start = '0;
      nxt_idx   = '0;
      update    = 1'b1;
    end else if (load) begin
      nxt_start = start_bits;
      nxt_idx   = '0;
      update    = 1'b1;
    end else if (!adv_n) begin
      nxt_idx   = idx_q + 1'b1;  // wraps modulo 2**AW
      update    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    start_q <= nxt_start;
    idx_q   <= nxt_idx;
  end
endmodule

// File: rtl/burst_order_map.sv
// Forms the burst address from start value and beat index.
module burst_order_map #(
  parameter int AW = 2
) (
  input  logic                  intlv,
  input  logic [AW-1:0]         base,
  input  logic [AW-1:0]         beat,
  output logic [AW-1:0]         addr_out
);
  import burst_seq_pkg::*;

  logic [AW-1:0] xor_addr;
  logic [AW-1:0] sum_addr;

  for (genvar b = 0; b < AW; b++) begin : g_xor
    assign xor_addr[b] = base[b] ^ beat[b];
  end

  assign sum_addr = base + beat;  // carry out dropped: modulo 2**AW

  always_comb begin
    if (order_e'(intlv) == ORDER_INTLV) addr_out = xor_addr;
    else                                addr_out = sum_addr;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_bits,
  input  logic          adv_n,
  input  logic          intlv,
  output logic [AW-1:0] addr,
  output logic          last_beat
);
  localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};

  logic [AW-1:0] nxt_start;
  logic [AW-1:0] nxt_idx;
  logic          update;
  logic [AW-1:0] nxt_addr;

  burst_beat_ctr #(.AW(AW)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .start_bits (start_bits),
    .adv_n      (adv_n),
    .nxt_start  (nxt_start),
    .nxt_idx    (nxt_idx),
    .update     (update)
  );

  burst_order_map #(.AW(AW)) u_map (
    .intlv    (intlv),
    .base     (nxt_start),
    .beat     (nxt_idx),
    .addr_out (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (update) begin
      addr      <= nxt_addr;
      last_beat <= !rst && (nxt_idx == LAST_IDX);
    end
  end
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic [AW-1:0] start_bits,
  input logic          adv_n,
  input logic          intlv,
  input logic [AW-1:0] addr,
  input logic          last_beat
);
  logic [AW-1:0] ref_start;
  logic [AW-1:0] ref_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_start <= '0;
      ref_idx   <= '0;
    end else if (load) begin
      ref_start <= start_bits;
      ref_idx   <= '0;
    end else if (!adv_n) begin
      ref_idx   <= ref_idx + 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (addr == '0) && !last_beat);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(start_bits)) && !last_beat);
  // R5
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(addr) && $stable(last_beat));
  // R3
  intlv_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && intlv) |=> addr == (ref_start ^ ref_idx));
  // R4
  linear_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && !intlv) |=> addr == AW'(ref_start + ref_idx));
  // R6
  wrap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !load && !adv_n) |=> !last_beat);
  // R7
  last_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (last_beat == (ref_idx == {AW{1'b1}})));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_burst_seq_chk (.*);

// File: tb/test_burst_seq.sv
module test_burst_seq;
  localparam int AW = 2;

  typedef struct {
    logic [AW-1:0] exp_addr;
    logic          exp_last;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [AW-1:0] start_bits = '0;
  logic          adv_n = 1'b1;
  logic          intlv = 1'b1;
  logic [AW-1:0] addr;
  logic          last_beat;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_start = '0;
  logic [AW-1:0] m_idx = '0;
  logic [AW-1:0] m_addr = '0;
  logic          m_last = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  burst_seq #(.AW(AW)) i_burst_seq (
    .clk(clk), .rst(rst), .load(load), .start_bits(start_bits),
    .adv_n(adv_n), .intlv(intlv), .addr(addr), .last_beat(last_beat)
  );

  // Drive one clock of stimulus and queue the result expected after it.
  task automatic step(input logic r, input logic ld, input logic [AW-1:0] s,
                      input logic an, input logic md, input string req);
    item_t it;
    @(negedge clk);
    rst = r; load = ld; start_bits = s; adv_n = an; intlv = md;
    if (r) begin
      m_start = '0; m_idx = '0; m_addr = '0; m_last = 1'b0;
    end else if (ld || !an) begin
      if (ld) begin m_start = s; m_idx = '0; end
      else        m_idx = m_idx + 1'b1;
      m_addr = md ? (m_start ^ m_idx) : AW'(m_start + m_idx);
      m_last = (m_idx == 2'd3);
    end
    it.exp_addr = m_addr; it.exp_last = m_last; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compare after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (addr !== it.exp_addr || last_beat !== it.exp_last) begin
          n_fail++;
          $display("FAIL %s: addr=%b last=%b expected addr=%b last=%b",
                   it.req, addr, last_beat, it.exp_addr, it.exp_last);
        end
      end
    end
  end

  initial begin
    step(1, 0, 0, 1, 1, "R1");
    step(1, 1, 3, 0, 1, "R1");
    // R3: every start value through a full burst, interleaved
    for (int s = 0; s < 4; s++) begin
      step(0, 1, AW'(s), 1, 1, "R2");
      for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, (k == 2) ? "R7" : "R3");
      step(0, 0, 0, 0, 1, "R6");
    end
    // R4: linear ordering, every start value
    for (int s = 0; s < 4; s++) begin
      step(0, 1, AW'(s), 1, 0, "R2");
      for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 0, "R6");
    end
    // R6: two full laps, linear from 10
    step(0, 1, 2'b10, 1, 0, "R2");
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 0, "R6");
    // R5: suspend mid-burst and on the last beat
    step(0, 1, 2'b01, 1, 1, "R2");
    step(0, 0, 0, 0, 1, "R3");
    step(0, 0, 2'b11, 1, 1, "R5");
    step(0, 0, 2'b10, 1, 1, "R5");
    step(0, 0, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, 1, "R5");
    step(0, 0, 0, 0, 1, "R6");
    // R8: reload partway, load together with advance
    step(0, 0, 0, 0, 1, "R3");
    step(0, 1, 2'b11, 0, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(0, 1, 2'b10, 1, 0, "R8");
    step(0, 0, 0, 0, 0, "R4");
    // R1: reset in the middle of a burst
    step(1, 0, 0, 0, 1, "R1");
    step(0, 0, 0, 1, 1, "R5");
    step(0, 0, 0, 1, 1, "R5");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule